// File: doc/BRIEF.md
# Binary64 Ordered Minimum/Maximum Unit

This unit takes two IEEE-754 binary64 operands and returns either the smaller or the larger of the two, chosen by a one-bit operation select. It also raises an invalid-operation flag when a signaling NaN is among the inputs. NaN handling depends on operand order. A NaN in the first operand always wins. A NaN in the second operand wins only when the first operand is not a NaN. A selected NaN leaves the unit bit-for-bit as it arrived, so a signaling NaN is never quieted. Negative zero counts as strictly below positive zero. All other values, including subnormals and infinities, are ordered numerically.

The unit is meant to sit in a floating-point execution pipeline as a fixed-latency stage. An operation enters with a valid strobe. One clock later the result and the flag are registered and appear together with a one-cycle output valid. The unit holds no other state. Every accepted operation is independent, and a new one may enter on every cycle.

Top module: `fmm_unit`

## Requirements
- R1: `outValid` is high in exactly the cycle after each cycle in which `inValid` is high. It is low after a cycle in which `inValid` is low.
- R2: While `rst` is high at a clock edge, `outValid` and `invalidFlag` are cleared and stay low.
- R3: An operand is a NaN when bits 62:52 are all ones and bits 51:0 are nonzero. It is signaling when bit 51 is 0. `invalidFlag` goes high with `outValid` when either operand is a signaling NaN. It stays low otherwise, including for quiet NaNs. `invalidFlag` is never high while `outValid` is low.
- R4: When operand A is any NaN, the result equals A, whatever B holds and for both operations.
- R5: When A is not a NaN and B is a NaN, the result equals B.
- R6: A signaling NaN that becomes the result keeps bit 51 at 0. All 64 bits are unchanged.
- R7: With `opMax`=0 (minimum) and both operands zero, the result is -0 (0x8000000000000000) if either operand is -0. It is +0 if both are +0.
- R8: With `opMax`=1 (maximum) and both operands zero, the result is +0 if either operand is +0. It is -0 only if both are -0.
- R9: With `opMax`=0 and no NaN or double-zero case, the result is A when A is strictly less than B, and B otherwise (equal values give B).
- R10: With `opMax`=1 and no NaN or double-zero case, the result is A when A is strictly greater than B, and B otherwise.
- R11: Ordering follows sign and magnitude. Between two negatives, the larger magnitude is the smaller value. Infinities and subnormals order as ordinary values.
- R12: The result always equals one of the two operands of the operation it answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation present on the inputs |
| opA | input | 64 | First binary64 operand |
| opB | input | 64 | Second binary64 operand |
| opMax | input | 1 | 0 selects minimum, 1 selects maximum |
| outValid | output | 1 | Result and flag are valid this cycle |
| result | output | 64 | Selected operand |
| invalidFlag | output | 1 | A signaling NaN was among the operands |

## Verification
The bound checker checks the following on every cycle:
- the one-cycle valid timing;
- the flag against its own detection of signaling NaNs in the previous inputs;
- the priority of a NaN in operand A;
- that each result is one of its two operands.

Only the bench scenarios can show the numeric ordering. This covers negatives, infinities and subnormals, the signed-zero results of both operations, and the B-NaN path. The bench also checks that equal operands return B, and it compares every result against a reference model based on an ordering key.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

  // Per-operand classification produced by the datapath classifiers.
  typedef struct packed {
    logic sign;
    logic isNan;
    logic isSnan;
    logic isZero;
  } fmm_class_t;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic capture;   // latch a new result and flag this cycle
    logic pickMax;   // 1: maximum, 0: minimum
  } fmm_strobe_t;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
  import fmm_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
  input  logic [DATA_W-1:0] operand,
  output fmm_class_t        cls
);

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              expAllOnes;
  logic              fracNonZero;

  assign expField    = operand[DATA_W-2 -: EXP_W];
  assign fracField   = operand[FRAC_W-1:0];
  assign expAllOnes  = &expField;
  assign fracNonZero = |fracField;

  always_comb begin
    cls.sign   = operand[DATA_W-1];
    cls.isNan  = expAllOnes & fracNonZero;
    // quiet bit is the top fraction bit; cleared means signaling
    cls.isSnan = expAllOnes & fracNonZero & ~fracField[FRAC_W-1];
    cls.isZero = ~(|expField) & ~fracNonZero;
  end

endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              lhsBelow
);

  logic              lhsSign;
  logic              rhsSign;
  logic [DATA_W-2:0] lhsMag;
  logic [DATA_W-2:0] rhsMag;

  assign lhsSign = lhs[DATA_W-1];
  assign rhsSign = rhs[DATA_W-1];
  assign lhsMag  = lhs[DATA_W-2:0];
  assign rhsMag  = rhs[DATA_W-2:0];

  // Strict sign-magnitude less-than; -0 sorts below +0.
  always_comb begin
    if (lhsSign != rhsSign) begin
      lhsBelow = lhsSign;
    end else if (lhsSign) begin
      lhsBelow = lhsMag > rhsMag;
    end else begin
      lhsBelow = lhsMag < rhsMag;
    end
  end

endmodule

// File: rtl/fmm_control.sv
module fmm_control
  import fmm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        opMax,
  output fmm_strobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe.capture = inValid & ~rst;
    strobe.pickMax = opMax;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
    end
  end

endmodule

// File: rtl/fmm_datapath.sv
module fmm_datapath
  import fmm_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  fmm_strobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              invalidFlag
);

  localparam int NUM_OPS = 2;

  logic [DATA_W-1:0] opVec   [NUM_OPS];
  fmm_class_t        clsVec  [NUM_OPS];
  logic              belowVec[NUM_OPS];  // [0]: A<B, [1]: B<A

  assign opVec[0] = opA;
  assign opVec[1] = opB;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_lane
    fmm_classify #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W)
    ) u_cls (
      .operand(opVec[i]),
      .cls    (clsVec[i])
    );

    fmm_order #(
      .DATA_W(DATA_W)
    ) u_ord (
      .lhs     (opVec[i]),
      .rhs     (opVec[NUM_OPS-1-i]),
      .lhsBelow(belowVec[i])
    );
  end

  logic [DATA_W-1:0] nextResult;
  logic              nextFlag;
  logic              zeroSign;

  always_comb begin
    zeroSign = strobe.pickMax ? (clsVec[0].sign & clsVec[1].sign)
                              : (clsVec[0].sign | clsVec[1].sign);
    if (clsVec[0].isNan) begin
      nextResult = opA;
    end else if (clsVec[1].isNan) begin
      nextResult = opB;
    end else if (clsVec[0].isZero && clsVec[1].isZero) begin
      nextResult = {zeroSign, {(DATA_W-1){1'b0}}};
    end else if (strobe.pickMax) begin
      nextResult = belowVec[1] ? opA : opB;
    end else begin
      nextResult = belowVec[0] ? opA : opB;
    end
    nextFlag = clsVec[0].isSnan | clsVec[1].isSnan;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      invalidFlag <= 1'b0;
    end else if (strobe.capture) begin
      result      <= nextResult;
      invalidFlag <= nextFlag;
    end else begin
      invalidFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
  import fmm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic        opMax,
  output logic        outValid,
  output logic [63:0] result,
  output logic        invalidFlag
);

  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;

  fmm_strobe_t strobe;

  fmm_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .opMax   (opMax),
    .strobe  (strobe),
    .outValid(outValid)
  );

  fmm_datapath #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .opA        (opA),
    .opB        (opB),
    .result     (result),
    .invalidFlag(invalidFlag)
  );

endmodule

// File: rtl/fmm_checker.sv
module fmm_checker (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic        opMax,
  input logic        outValid,
  input logic [63:0] result,
  input logic        invalidFlag
);

  function automatic logic chkNan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
  endfunction

  function automatic logic chkSnan(input logic [63:0] v);
    return chkNan(v) && !v[51];
  endfunction

  logic opMaxSeen;
  assign opMaxSeen = opMax;

  // R1: one-cycle valid latency
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inValid)) |-> outValid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(inValid)) |-> !outValid);

  // R3: flag matches signaling NaN presence in the previous inputs
  a_r3_flag_snan: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inValid)) |->
      (invalidFlag == (chkSnan($past(opA)) || chkSnan($past(opB)))));
  a_r3_flag_only_valid: assert property (@(posedge clk) disable iff (rst)
    invalidFlag |-> outValid);

  // R4: NaN in A wins regardless of opMax
  a_r4_a_nan_wins: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inValid) && chkNan($past(opA)) && ($past(opMaxSeen) || !$past(opMaxSeen)))
      |-> (result == $past(opA)));

  // R12: result is one of the two operands
  a_r12_from_operand: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(inValid)) |->
      (result == $past(opA) || result == $past(opB)));

endmodule

bind fmm_unit fmm_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .opA        (opA),
  .opB        (opB),
  .opMax      (opMax),
  .outValid   (outValid),
  .result     (result),
  .invalidFlag(invalidFlag)
);

// File: tb/fmm_unit_test.sv
`timescale 1ns/1ps
module fmm_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        opMax = 1'b0;
  logic        outValid;
  logic [63:0] result;
  logic        invalidFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [63:0] POS_ZERO = 64'h0000000000000000;
  localparam logic [63:0] NEG_ZERO = 64'h8000000000000000;
  localparam logic [63:0] POS_INF  = 64'h7FF0000000000000;
  localparam logic [63:0] NEG_INF  = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN1    = 64'h7FF8000000000001;
  localparam logic [63:0] QNAN2    = 64'hFFF8000000000abc;
  localparam logic [63:0] SNAN1    = 64'h7FF0000000000005;
  localparam logic [63:0] SNAN2    = 64'hFFF4000000000000;
  localparam logic [63:0] ONE      = 64'h3FF0000000000000;
  localparam logic [63:0] TWO      = 64'h4000000000000000;
  localparam logic [63:0] NEG_ONE  = 64'hBFF0000000000000;
  localparam logic [63:0] NEG_TWO  = 64'hC000000000000000;
  localparam logic [63:0] SUB_SM   = 64'h0000000000000001;
  localparam logic [63:0] SUB_BG   = 64'h000FFFFFFFFFFFFF;
  localparam logic [63:0] NSUB_SM  = 64'h8000000000000001;

  always #10 clk = ~clk;

  fmm_unit uut (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .opA        (opA),
    .opB        (opB),
    .opMax      (opMax),
    .outValid   (outValid),
    .result     (result),
    .invalidFlag(invalidFlag)
  );

  function automatic bit isNanF(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  function automatic bit isSnanF(input logic [63:0] v);
    return isNanF(v) && (v[51] == 1'b0);
  endfunction

  // Total-order key: unsigned compare of keys gives numeric order, -0 below +0.
  function automatic logic [63:0] orderKey(input logic [63:0] v);
    return v[63] ? ~v : (v | 64'h8000000000000000);
  endfunction

  function automatic logic [63:0] refResult(input logic [63:0] a, input logic [63:0] b,
                                            input bit mx);
    if (isNanF(a)) return a;
    if (isNanF(b)) return b;
    if (mx) return (orderKey(a) > orderKey(b)) ? a : b;
    return (orderKey(a) < orderKey(b)) ? a : b;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one op, check on the following negedge, then drop inValid.
  task automatic runOp(input logic [63:0] a, input logic [63:0] b, input bit mx,
                       input string tag);
    logic [63:0] exp;
    bit expFlag;
    @(negedge clk);
    opA = a; opB = b; opMax = mx; inValid = 1'b1;
    exp = refResult(a, b, mx);
    expFlag = isSnanF(a) || isSnanF(b);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, {tag, " R1 outValid"}, {63'd0, outValid}, 64'd1);
    check(result == exp, tag, result, exp);
    check(invalidFlag == expFlag, {tag, " R3 flag"}, {63'd0, invalidFlag},
          {63'd0, expFlag});
  endtask

  function automatic logic [63:0] genVal(input int kind, input logic [63:0] other);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case (kind)
      0: return {$urandom_range(1, 0) == 1, 11'h7FF, 52'd0};
      1: return {$urandom_range(1, 0) == 1, 63'd0};
      2: return {r[63], 11'h7FF, 1'b1, r[50:0]};
      3: return {r[63], 11'h7FF, 1'b0, r[50:1], 1'b1};
      4: return {r[63], 11'd0, r[51:0]};
      5: return other;
      6: return {~other[63], other[62:0]};
      default: begin
        if (r[62:52] == 11'h7FF) r[62] = 1'b0;
        return r;
      end
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    inValid = 1'b1; opA = SNAN1; opB = SNAN2;
    @(negedge clk);
    // R2: reset holds outputs low even with valid inputs presented
    check(outValid == 1'b0, "R2 reset outValid", {63'd0, outValid}, 64'd0);
    check(invalidFlag == 1'b0, "R2 reset flag", {63'd0, invalidFlag}, 64'd0);
    inValid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 idle outValid", {63'd0, outValid}, 64'd0);

    // R4 / R5 / R6 NaN priority and pass-through
    runOp(QNAN1, ONE, 1'b0, "R4 qnanA min");
    runOp(SNAN1, QNAN2, 1'b1, "R4 snanA max");
    runOp(QNAN2, SNAN2, 1'b0, "R4 qnanA snanB flag R3");
    runOp(TWO, QNAN1, 1'b1, "R5 qnanB max");
    runOp(NEG_INF, SNAN2, 1'b0, "R5 R6 snanB kept");
    check(result[51] == 1'b0, "R6 quiet bit untouched", {63'd0, result[51]}, 64'd0);
    runOp(SNAN1, ONE, 1'b0, "R6 snanA kept");
    check(result == SNAN1, "R6 exact bits", result, SNAN1);
    runOp(QNAN1, QNAN2, 1'b0, "R3 quiet no flag");

    // R7 / R8 zeros
    runOp(POS_ZERO, NEG_ZERO, 1'b0, "R7 min +0,-0");
    runOp(NEG_ZERO, POS_ZERO, 1'b0, "R7 min -0,+0");
    runOp(POS_ZERO, POS_ZERO, 1'b0, "R7 min +0,+0");
    runOp(NEG_ZERO, POS_ZERO, 1'b1, "R8 max -0,+0");
    runOp(POS_ZERO, NEG_ZERO, 1'b1, "R8 max +0,-0");
    runOp(NEG_ZERO, NEG_ZERO, 1'b1, "R8 max -0,-0");

    // R9 / R10 / R11 ordering
    runOp(ONE, TWO, 1'b0, "R9 min positive");
    runOp(TWO, TWO, 1'b0, "R9 min equal gives B");
    runOp(ONE, TWO, 1'b1, "R10 max positive");
    runOp(NEG_ONE, NEG_TWO, 1'b0, "R11 min negatives");
    runOp(NEG_ONE, NEG_TWO, 1'b1, "R11 max negatives");
    runOp(POS_INF, TWO, 1'b1, "R11 max inf");
    runOp(NEG_INF, NEG_TWO, 1'b0, "R11 min -inf");
    runOp(SUB_BG, SUB_SM, 1'b0, "R11 min subnormals");
    runOp(NSUB_SM, POS_ZERO, 1'b1, "R11 max tiny neg vs +0");
    runOp(NEG_ZERO, SUB_SM, 1'b0, "R11 min -0 vs subnormal");

    // back-to-back ops, R1 every cycle
    @(negedge clk);
    opA = ONE; opB = NEG_ONE; opMax = 1'b1; inValid = 1'b1;
    @(negedge clk);
    check(outValid && result == ONE, "R1 R10 b2b first", result, ONE);
    opA = ONE; opB = NEG_ONE; opMax = 1'b0;
    @(negedge clk);
    check(outValid && result == NEG_ONE, "R1 R9 b2b second", result, NEG_ONE);
    inValid = 1'b0;
    @(negedge clk);
    check(!outValid && !invalidFlag, "R1 R3 after drop", {62'd0, outValid, invalidFlag}, 64'd0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a;
      logic [63:0] b;
      a = genVal($urandom_range(7, 0), 64'd0);
      b = genVal($urandom_range(7, 0), a);
      runOp(a, b, $urandom_range(1, 0) == 1, "R12 random");
      if ($urandom_range(3, 0) == 0) begin
        @(negedge clk);
        check(outValid == 1'b0, "R1 random gap", {63'd0, outValid}, 64'd0);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule